// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives stereo audio from an external serial audio master. The master supplies the bit clock, the word-select line and the data line. All three are brought into the system clock domain through synchronizer chains, and rising edges of the bit clock are found by edge detection. The system clock must therefore run well above the bit clock. Sampling once every eight system clocks, as the bench does, leaves plenty of margin.

Three framings are supported. In the standard delayed format, the word starts one bit after the word-select change. In the left-aligned format, the MSB follows the word-select change at once. In the right-aligned format, the word ends on the last bit before the next word-select change. The word length, 16 or 32 bits, is set by a static input before reception starts. Slot boundaries are taken only from word-select transitions. The slot length can be anything, and it does not have to match the word length. Each completed left/right pair appears on two parallel outputs, marked by a single-cycle strobe.

The format and the word length are static: change them only while reset is held.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and directly after it, `pair_valid` is 0 and both sample outputs are all zeros.
- R2: With `fmt`=0 (delayed standard format), word-select low marks the left channel and high marks the right. The bit taken at the first rising bit-clock edge after a word-select change is the LSB side of the old word. The new word's MSB is taken at the second rising edge.
- R3: With `fmt`=1 (left-aligned; the code 3 behaves the same), word-select high marks left and low marks right. The MSB is the bit taken at the first rising bit-clock edge after the word-select change.
- R4: With `fmt`=2 (right-aligned), word-select high marks left and low marks right. The word is formed from the bits taken at the last N rising edges before the word-select change, and the last of these bits is the LSB.
- R5: With `wl32`=0, N is 16 and each word is returned in bits [15:0] with bits [31:16] zero. With `wl32`=1, N is 32 and all 32 bits are used.
- R6: In formats 0 and 1, bits past the first N of a slot have no effect on the output word.
- R7: In formats 0 and 1, a slot shorter than N bits places its bits at the top of the N-bit word and zero-fills the missing lower bits.
- R8: `pair_valid` is high for exactly one system cycle per pair. The pulse comes only after the right slot has been closed by the next word-select change. `left_out`/`right_out` are updated in that cycle and held until the next pulse.
- R9: The slot that runs before the first word-select change after reset is discarded. A right word with no left word before it since the last pair is dropped.
- R10: In format 2, bits taken earlier in a slot than its last N bits have no effect on the output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Framing: 0 delayed standard, 1 left-aligned, 2 right-aligned, 3 as 1 |
| wl32 | input | 1 | Word length: 0 = 16 bits, 1 = 32 bits |
| sck_in | input | 1 | Bit clock from the master (asynchronous) |
| ws_in | input | 1 | Word select from the master (asynchronous) |
| sd_in | input | 1 | Serial data from the master (asynchronous) |
| left_out | output | 32 | Left sample of the last pair, right-aligned |
| right_out | output | 32 | Right sample of the last pair, right-aligned |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench attacks the one-bit delay of the standard format. A design that ignored the delay would return every word shifted by one bit, with the previous word's LSB as its MSB and the channels swapped. Slots longer than the word, filled with junk past the word, expose a design that keeps shifting past N bits. Slots shorter than the word expose one that fails to zero-fill. In the right-aligned format, junk placed ahead of the word catches a design that masks the wrong end of the history. The pair count is checked just before and just after the closing word-select edge. A receiver that fires early, or that keeps the partial lead-in slot, would report the wrong number of pairs.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_DELAYED = 2'd0,
    FMT_LALIGN  = 2'd1,
    FMT_RALIGN  = 2'd2,
    FMT_LALIGN2 = 2'd3
  } aud_fmt_e;

  localparam int unsigned AUD_SHORT_W = 16;
  localparam int unsigned AUD_LONG_W  = 32;

endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/aud_bit_tap.sv
module aud_bit_tap (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic ws_s,
  input  logic sd_s,
  output logic bit_stb,
  output logic bit_ws,
  output logic bit_sd
);

  logic sck_d;
  logic sck_rise;

  assign sck_rise = sck_s & ~sck_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      bit_stb <= 1'b0;
      bit_ws  <= 1'b0;
      bit_sd  <= 1'b0;
    end else begin
      sck_d   <= sck_s;
      bit_stb <= sck_rise;
      if (sck_rise) begin
        bit_ws <= ws_s;
        bit_sd <= sd_s;
      end
    end
  end

  // a rising edge needs a low sample first, so strobes never touch
  p_strobe_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/aud_deser.sv
module aud_deser
  import aud_rx_pkg::*;
#(
  parameter int unsigned SHORT_W = AUD_SHORT_W,
  parameter int unsigned LONG_W  = AUD_LONG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt,
  input  logic              wl32,
  input  logic              bit_stb,
  input  logic              bit_ws,
  input  logic              bit_sd,
  output logic              word_done,
  output logic              word_left,
  output logic [LONG_W-1:0] word_data
);

  localparam int unsigned MAX_W = LONG_W;
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);

  function automatic logic [CNT_W-1:0] word_len(input logic long_sel);
    return long_sel ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
  endfunction

  function automatic logic [MAX_W-1:0] low_mask(input logic [CNT_W-1:0] n);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_W; i++) m[i] = (CNT_W'(i) < n);
    return m;
  endfunction

  function automatic logic [MAX_W-1:0] put_bit(input logic b, input logic [CNT_W-1:0] pos);
    return {{(MAX_W-1){1'b0}}, b} << pos;
  endfunction

  logic             is_delayed, is_ralign;
  logic [CNT_W-1:0] wlen;
  logic             ws_d1;
  logic             seen_one;
  logic             eff_ws, eff_ok, eff_left;
  logic             eff_last, eff_seen;
  logic             slot_boundary;
  logic             slot_open, slot_left;
  logic [CNT_W-1:0] cnt;
  logic [MAX_W-1:0] acc;
  logic [MAX_W-1:0] hist;
  logic [MAX_W-1:0] finished;

  assign is_delayed = (fmt == FMT_DELAYED);
  assign is_ralign  = (fmt == FMT_RALIGN);
  assign wlen       = word_len(wl32);

  // the delayed format sees word select one bit late
  assign eff_ws   = is_delayed ? ws_d1 : bit_ws;
  assign eff_ok   = is_delayed ? seen_one : 1'b1;
  assign eff_left = is_delayed ? ~eff_ws : eff_ws;

  assign slot_boundary = bit_stb & eff_ok & eff_seen & (eff_ws != eff_last);
  assign finished      = is_ralign ? (hist & low_mask(wlen)) : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_d1     <= 1'b0;
      seen_one  <= 1'b0;
      eff_last  <= 1'b0;
      eff_seen  <= 1'b0;
      slot_open <= 1'b0;
      slot_left <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      hist      <= '0;
      word_done <= 1'b0;
      word_left <= 1'b0;
      word_data <= '0;
    end else begin
      word_done <= 1'b0;
      if (bit_stb) begin
        ws_d1    <= bit_ws;
        seen_one <= 1'b1;
        if (eff_ok) begin
          eff_last <= eff_ws;
          eff_seen <= 1'b1;
        end
        hist <= {hist[MAX_W-2:0], bit_sd};
        if (slot_boundary) begin
          word_done <= slot_open;
          word_left <= slot_left;
          word_data <= finished;
          slot_open <= 1'b1;
          slot_left <= eff_left;
          cnt       <= CNT_W'(1);
          acc       <= put_bit(bit_sd, wlen - CNT_W'(1));
        end else if (cnt < wlen) begin
          acc <= acc | put_bit(bit_sd, wlen - cnt - CNT_W'(1));
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // a finished word follows a bit strobe by one cycle
  p_done_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(bit_stb));

  // a word is only handed on once a slot has been opened by an earlier boundary
  p_done_needs_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> slot_open);

  // short words never carry bits above the short width
  p_short_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !wl32) |-> ((word_data & ~low_mask(CNT_W'(SHORT_W))) == '0));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned SHORT_W     = AUD_SHORT_W,
  parameter int unsigned LONG_W      = AUD_LONG_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt,
  input  logic              wl32,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic [LONG_W-1:0] left_out,
  output logic [LONG_W-1:0] right_out,
  output logic              pair_valid
);

  localparam int unsigned MAX_W = LONG_W;

  logic [2:0]       pins_s;
  logic             bit_stb, bit_ws, bit_sd;
  logic             word_done, word_left;
  logic [MAX_W-1:0] word_data;
  logic [MAX_W-1:0] left_hold;
  logic             have_left;

  aud_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck_in, ws_in, sd_in}),
    .q     (pins_s)
  );

  aud_bit_tap u_tap (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (pins_s[2]),
    .ws_s    (pins_s[1]),
    .sd_s    (pins_s[0]),
    .bit_stb (bit_stb),
    .bit_ws  (bit_ws),
    .bit_sd  (bit_sd)
  );

  aud_deser #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .wl32      (wl32),
    .bit_stb   (bit_stb),
    .bit_ws    (bit_ws),
    .bit_sd    (bit_sd),
    .word_done (word_done),
    .word_left (word_left),
    .word_data (word_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold  <= '0;
      have_left  <= 1'b0;
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (word_done) begin
        if (word_left) begin
          left_hold <= word_data;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_out   <= left_hold;
          right_out  <= word_data;
          pair_valid <= 1'b1;
          have_left  <= 1'b0;
        end
      end
    end
  end

  p_pair_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  p_pair_after_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(word_done && !word_left));

  p_outputs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_out) && $stable(right_out)));

  generate
    if (LONG_W > SHORT_W) begin : g_upper_chk
      p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !wl32) |->
          (left_out[LONG_W-1:SHORT_W] == '0 && right_out[LONG_W-1:SHORT_W] == '0));
    end
  endgenerate

endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int MAXBITS    = 1024;
  localparam int MAXPAIRS   = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        wl32 = 1'b0;
  logic        sck_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
  logic [31:0] left_out, right_out;
  logic        pair_valid;

  int checks = 0;
  int errors = 0;

  logic        ws_a [MAXBITS];
  logic        sd_a [MAXBITS];
  int          nbits;
  logic [31:0] exp_l [16];
  logic [31:0] exp_r [16];
  logic [31:0] got_l [MAXPAIRS];
  logic [31:0] got_r [MAXPAIRS];
  int          got_n = 0;
  logic        pv_prev = 1'b0;
  int          double_pulses = 0;

  serial_audio_rx dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt        (fmt),
    .wl32       (wl32),
    .sck_in     (sck_in),
    .ws_in      (ws_in),
    .sd_in      (sd_in),
    .left_out   (left_out),
    .right_out  (right_out),
    .pair_valid (pair_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (pair_valid && pv_prev) double_pulses++;
    pv_prev <= pair_valid;
    if (pair_valid && got_n < MAXPAIRS) begin
      got_l[got_n] = left_out;
      got_r[got_n] = right_out;
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sck_in = 1'b0; ws_in = 1'b0; sd_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic add_bit(input logic w, input logic d);
    ws_a[nbits] = w;
    sd_a[nbits] = d;
    nbits++;
  endtask

  // expected word for a slot, computed from the requirements
  function automatic logic [31:0] slot_expect(input logic [1:0] f, input int wl, input int sl,
                                              input logic [31:0] w);
    logic [31:0] e;
    e = w;
    if (f != 2'd2 && sl < wl) begin
      for (int i = 0; i < wl - sl; i++) e[i] = 1'b0;
    end
    return e;
  endfunction

  task automatic add_slot(input logic [1:0] f, input int wl, input int sl,
                          input logic w_lvl, input logic [31:0] w);
    for (int i = 0; i < sl; i++) begin
      int j;
      logic b;
      b = 1'($urandom);
      if (f == 2'd2) begin
        j = i - (sl - wl);
        if (j >= 0) b = w[wl-1-j];
      end else if (i < wl) begin
        b = w[wl-1-i];
      end
      add_bit(w_lvl, b);
    end
  endtask

  task automatic drive_bits(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      ws_in = ws_a[i];
      sd_in = sd_a[i];
      sck_in = 1'b0;
      repeat (HALF_BIT) @(negedge clk);
      sck_in = 1'b1;
      repeat (HALF_BIT) @(negedge clk);
    end
    sck_in = 1'b0;
  endtask

  task automatic run_case(input logic [1:0] f, input bit w32, input int sl, input int nfr,
                          input string tag);
    int wl, tr_start, base;
    logic lval;
    do_reset();
    fmt = f;
    wl32 = w32;
    wl = w32 ? 32 : 16;
    lval = (f == 2'd0) ? 1'b0 : 1'b1;
    nbits = 0;
    for (int i = 0; i < 3; i++) add_bit(~lval, 1'($urandom));
    for (int fr = 0; fr < nfr; fr++) begin
      logic [31:0] wl_w, wr_w;
      wl_w = $urandom;
      wr_w = $urandom;
      if (!w32) begin
        wl_w[31:16] = 16'h0;
        wr_w[31:16] = 16'h0;
      end
      if (fr == 0) wl_w[0] = 1'b1;
      exp_l[fr] = slot_expect(f, wl, sl, wl_w);
      exp_r[fr] = slot_expect(f, wl, sl, wr_w);
      add_slot(f, wl, sl, lval, wl_w);
      add_slot(f, wl, sl, ~lval, wr_w);
    end
    tr_start = nbits;
    for (int i = 0; i < 3; i++) add_bit(lval, 1'($urandom));
    if (f == 2'd0) begin
      for (int i = 0; i < nbits - 1; i++) ws_a[i] = ws_a[i+1];
    end
    base = got_n;
    drive_bits(0, tr_start);
    repeat (20) @(negedge clk);
    // R8: last pair must wait for the closing word-select change
    chk(got_n - base == nfr - 1, {tag, " R8 early pair"}, 32'(got_n - base), 32'(nfr - 1));
    drive_bits(tr_start, nbits);
    repeat (20) @(negedge clk);
    // R9: lead-in slot discarded, one pair per frame
    chk(got_n - base == nfr, {tag, " R9 pair count"}, 32'(got_n - base), 32'(nfr));
    for (int k = 0; k < nfr && base + k < got_n; k++) begin
      chk(got_l[base+k] == exp_l[k], {tag, " left"}, got_l[base+k], exp_l[k]);
      chk(got_r[base+k] == exp_r[k], {tag, " right"}, got_r[base+k], exp_r[k]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1: reset state
    chk(pair_valid == 1'b0, "R1 valid", 32'(pair_valid), 32'd0);
    chk(left_out == 32'd0, "R1 left", left_out, 32'd0);
    chk(right_out == 32'd0, "R1 right", right_out, 32'd0);

    run_case(2'd0, 1'b0, 16, 4, "R2 delayed 16/16");
    run_case(2'd0, 1'b1, 32, 3, "R2 R5 delayed 32/32");
    run_case(2'd0, 1'b0, 20, 3, "R6 delayed long slot");
    run_case(2'd0, 1'b0, 12, 3, "R7 delayed short slot");
    run_case(2'd1, 1'b0, 32, 3, "R3 R6 lalign 16 in 32");
    run_case(2'd1, 1'b1, 24, 3, "R3 R7 lalign 32 in 24");
    run_case(2'd3, 1'b0, 16, 2, "R3 code3 16/16");
    run_case(2'd2, 1'b0, 32, 3, "R4 R10 ralign 16 in 32");
    run_case(2'd2, 1'b1, 32, 3, "R4 R5 ralign 32/32");
    run_case(2'd2, 1'b0, 16, 3, "R4 ralign 16/16");

    for (int t = 0; t < 8; t++) begin
      logic [1:0] f;
      bit w;
      int wl, sl;
      f = 2'($urandom_range(0, 2));
      w = 1'($urandom);
      wl = w ? 32 : 16;
      if (f == 2'd2) sl = $urandom_range(wl, 40);
      else           sl = $urandom_range(wl - 4, 40);
      run_case(f, w, sl, 3, "R2 R3 R4 random");
    end

    // R8: strobe never lasts two cycles
    chk(double_pulses == 0, "R8 single pulse", 32'(double_pulses), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule